// File: doc/BRIEF.md
# Compact RISC Decode and Execute Unit

This block is the decode and execute step of a small 16-bit core with eight registers. It is purely combinational. It takes one instruction word, the values already read for the two source registers, and the address of the instruction. In the same cycle it produces the ALU result, which register is written and whether the write happens, the load and store strobes, and whether control flow is redirected and to which address. It also produces the return address that a call would save.

The register file, the memories and any pipeline registers sit outside the block. A pipeline places it between its decode and memory registers. A testbench can drive it directly with no clock.

Top module: `rx16_exec`

## Requirements
- R1: Opcode bits [15:13] = 000 select register-register operations, decoded from function bits [3:0]. The fields are rs [12:10], rt [9:7] and rd [6:4]. Function 0000 gives rs+rt, 0001 gives rs-rt, 0010 gives rs AND rt and 0011 gives rs OR rt. The result appears on `alu_out`, with `wr_idx` = rd and `wr_en` = 1.
- R2: Function 0100 shifts rs left by exactly one bit, filling with zero. Function 0101 shifts it right by one bit, filling with zero. Function 0110 shifts it right by one bit and copies the sign bit into the top position. Each result is written to rd.
- R3: Function 0111 writes 1 to rd when rs is less than rt as signed two's complement values, and writes 0 otherwise, including when the two are equal.
- R4: Function 1000 raises `redirect` with `target` = rs and does not write a register. Function codes 1001 to 1111 do not write a register and do not redirect.
- R5: Opcode 001 writes the rt register value plus the sign-extended 7-bit immediate in bits [6:0] back to register rt.
- R6: For opcodes 100 (load) and 101 (store), `alu_out` is rs plus the sign-extended immediate. A load raises `mem_rd` and writes to rt. A store raises `mem_wr` and writes no register.
- R7: Opcode 010 redirects to the zero-extended 13-bit field in bits [12:0]. Opcode 011 redirects to the same address and also writes pc+2 to r7, with pc+2 on `alu_out`.
- R8: Opcode 110 is taken when rs equals rt, and opcode 111 is taken when they differ. A taken branch raises `redirect` with `target` = pc + sign-extended immediate + 2. A branch that is not taken leaves `redirect` low.
- R9: A write whose destination index is 0 is suppressed: `wr_en` stays 0.
- R10: `mem_rd` and `mem_wr` are never high together, and neither is high while `redirect` is high. `target` is 0 whenever `redirect` is low. `link_val` always equals pc+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Instruction word |
| rs_val | input | W | Value of the first source register |
| rt_val | input | W | Value of the second source register |
| pc | input | W | Address of the instruction |
| alu_out | output | W | Result, memory address or link value |
| wr_idx | output | 3 | Destination register index |
| wr_en | output | 1 | Register write enable |
| mem_rd | output | 1 | Load strobe |
| mem_wr | output | 1 | Store strobe |
| redirect | output | 1 | Branch taken or jump |
| target | output | W | Next fetch address when redirecting |
| link_val | output | W | pc + 2 |

## Verification
The cases hardest to reach from the ports are the ones where a correct-looking result is the wrong one. The first is the sign boundary of the signed compare and the arithmetic shift. Here the bench applies operands such as 0xFFFF against 1 and 0x8001, where an unsigned compare or a logical shift gives a different answer. The second is a write that must be suppressed even though the opcode normally writes. The bench reaches it by encoding immediate, load and R-type instructions whose destination field is zero, and then checking `wr_en` at the port. Branches use a negative immediate, so the target wraps back to the instruction's own address.

// File: rtl/rx16_exec.sv
module rx16_exec #(
  parameter int W = 16
) (
  input  logic [15:0]  instr,
  input  logic [W-1:0] rs_val,
  input  logic [W-1:0] rt_val,
  input  logic [W-1:0] pc,
  output logic [W-1:0] alu_out,
  output logic [2:0]   wr_idx,
  output logic         wr_en,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic         redirect,
  output logic [W-1:0] target,
  output logic [W-1:0] link_val
);

  localparam logic [2:0] OP_R    = 3'b000;
  localparam logic [2:0] OP_ADDI = 3'b001;
  localparam logic [2:0] OP_J    = 3'b010;
  localparam logic [2:0] OP_JAL  = 3'b011;
  localparam logic [2:0] OP_LW   = 3'b100;
  localparam logic [2:0] OP_SW   = 3'b101;
  localparam logic [2:0] OP_BEQ  = 3'b110;
  localparam logic [2:0] OP_BNE  = 3'b111;
  localparam logic [2:0] LINK_REG = 3'd7;

  logic [2:0]   op, rs_f, rt_f, rd_f;
  logic [3:0]   fn;
  logic [W-1:0] simm, jaddr;
  logic         wr_req, jump;
  logic [W-1:0] jdest;

  assign op    = instr[15:13];
  assign rs_f  = instr[12:10];
  assign rt_f  = instr[9:7];
  assign rd_f  = instr[6:4];
  assign fn    = instr[3:0];
  assign simm  = {{(W-7){instr[6]}}, instr[6:0]};
  assign jaddr = {{(W-13){1'b0}}, instr[12:0]};

  assign link_val = pc + W'(2);

  always_comb begin
    alu_out = '0;
    wr_idx  = rd_f;
    wr_req  = 1'b0;
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    jump    = 1'b0;
    jdest   = '0;
    case (op)
      OP_R: begin
        wr_req = 1'b1;
        case (fn)
          4'b0000: alu_out = rs_val + rt_val;
          4'b0001: alu_out = rs_val - rt_val;
          4'b0010: alu_out = rs_val & rt_val;
          4'b0011: alu_out = rs_val | rt_val;
          4'b0100: alu_out = {rs_val[W-2:0], 1'b0};
          4'b0101: alu_out = {1'b0, rs_val[W-1:1]};
          4'b0110: alu_out = {rs_val[W-1], rs_val[W-1:1]};
          4'b0111: alu_out = W'($signed(rs_val) < $signed(rt_val));
          4'b1000: begin
            wr_req = 1'b0;
            jump   = 1'b1;
            jdest  = rs_val;
          end
          default: wr_req = 1'b0;
        endcase
      end
      OP_ADDI: begin
        alu_out = rt_val + simm;
        wr_idx  = rt_f;
        wr_req  = 1'b1;
      end
      OP_J: begin
        jump  = 1'b1;
        jdest = jaddr;
      end
      OP_JAL: begin
        jump    = 1'b1;
        jdest   = jaddr;
        alu_out = link_val;
        wr_idx  = LINK_REG;
        wr_req  = 1'b1;
      end
      OP_LW: begin
        alu_out = rs_val + simm;
        wr_idx  = rt_f;
        wr_req  = 1'b1;
        mem_rd  = 1'b1;
      end
      OP_SW: begin
        alu_out = rs_val + simm;
        mem_wr  = 1'b1;
      end
      OP_BEQ, OP_BNE: begin
        jump  = (rs_val == rt_val) ^ (op == OP_BNE);
        jdest = link_val + simm;
      end
      default: ;
    endcase
  end

  assign wr_en    = wr_req && (wr_idx != 3'd0);
  assign redirect = jump;
  assign target   = jump ? jdest : '0;

endmodule

module rx16_exec_chk #(
  parameter int W = 16
) (
  input logic [15:0]  instr,
  input logic [W-1:0] rs_val,
  input logic [W-1:0] rt_val,
  input logic [W-1:0] pc,
  input logic [W-1:0] alu_out,
  input logic [2:0]   wr_idx,
  input logic         wr_en,
  input logic         mem_rd,
  input logic         mem_wr,
  input logic         redirect,
  input logic [W-1:0] target,
  input logic [W-1:0] link_val
);
  logic known;
  assign known = !$isunknown({instr, rs_val, rt_val, pc});

  always_comb begin
    if (known) begin
      a_r9_no_r0_write: assert (!(wr_en && wr_idx == 3'd0))
        else $error("write enabled toward r0");
      a_r10_strobes_exclusive: assert (!(mem_rd && mem_wr))
        else $error("load and store strobes together");
      a_r10_no_mem_on_redirect: assert (!(redirect && (mem_rd || mem_wr)))
        else $error("memory strobe during redirect");
      a_r10_target_idle: assert (redirect || target == '0)
        else $error("target nonzero without redirect");
      a_r6_store_no_write: assert (!(mem_wr && wr_en))
        else $error("store also writes a register");
      a_r7_link_dest: assert (!(wr_en && redirect) || (wr_idx == 3'd7 && alu_out == link_val))
        else $error("call writes wrong register or value");
    end
  end
endmodule

bind rx16_exec rx16_exec_chk #(.W(W)) u_chk (.*);

// File: tb/sim_rx16_exec.sv
module sim_rx16_exec;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0]  instr;
  logic [W-1:0] rs_val, rt_val, pc;
  logic [W-1:0] alu_out, target, link_val;
  logic [2:0]   wr_idx;
  logic         wr_en, mem_rd, mem_wr, redirect;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  rx16_exec #(.W(W)) u0 (
    .instr(instr), .rs_val(rs_val), .rt_val(rt_val), .pc(pc),
    .alu_out(alu_out), .wr_idx(wr_idx), .wr_en(wr_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .redirect(redirect),
    .target(target), .link_val(link_val)
  );

  function automatic logic [15:0] rty(input logic [2:0] s, input logic [2:0] t,
                                      input logic [2:0] d, input logic [3:0] f);
    return {3'b000, s, t, d, f};
  endfunction
  function automatic logic [15:0] ity(input logic [2:0] o, input logic [2:0] s,
                                      input logic [2:0] t, input logic [6:0] imm);
    return {o, s, t, imm};
  endfunction

  task automatic ck(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] i, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] p);
    @(negedge clk);
    instr = i; rs_val = a; rt_val = b; pc = p;
    #1;
  endtask

  task automatic t_idle;
    drive(16'h0000, 16'h0005, 16'h0003, 16'h0000);
    ck("R9 idle wr_en", W'(wr_en), 0);
    ck("R10 idle redirect", W'(redirect), 0);
    ck("R10 idle target", target, 0);
    ck("R10 idle strobes", W'({mem_rd, mem_wr}), 0);
  endtask

  task automatic t_rtype;
    drive(rty(3'd1, 3'd2, 3'd3, 4'b0000), 16'h1234, 16'h0F0F, 16'h0010);
    ck("R1 add", alu_out, 16'h2143);
    ck("R1 add wr_idx", W'(wr_idx), 3);
    ck("R1 add wr_en", W'(wr_en), 1);
    drive(rty(3'd1, 3'd2, 3'd4, 4'b0001), 16'h0005, 16'h0007, 16'h0010);
    ck("R1 sub", alu_out, 16'hFFFE);
    drive(rty(3'd1, 3'd2, 3'd5, 4'b0010), 16'hF0F0, 16'h3C3C, 16'h0010);
    ck("R1 and", alu_out, 16'h3030);
    drive(rty(3'd1, 3'd2, 3'd6, 4'b0011), 16'hF0F0, 16'h3C3C, 16'h0010);
    ck("R1 or", alu_out, 16'hFCFC);
    ck("R10 link", link_val, 16'h0012);
  endtask

  task automatic t_shift;
    drive(rty(3'd1, 3'd0, 3'd2, 4'b0100), 16'h8001, 16'h0000, 16'h0000);
    ck("R2 sll", alu_out, 16'h0002);
    drive(rty(3'd1, 3'd0, 3'd2, 4'b0101), 16'h8001, 16'h0000, 16'h0000);
    ck("R2 srl", alu_out, 16'h4000);
    drive(rty(3'd1, 3'd0, 3'd2, 4'b0110), 16'h8001, 16'h0000, 16'h0000);
    ck("R2 sra", alu_out, 16'hC000);
    drive(rty(3'd1, 3'd0, 3'd2, 4'b0110), 16'h4002, 16'h0000, 16'h0000);
    ck("R2 sra positive", alu_out, 16'h2001);
  endtask

  task automatic t_slt;
    drive(rty(3'd1, 3'd2, 3'd3, 4'b0111), 16'hFFFF, 16'h0001, 16'h0000);
    ck("R3 slt neg<pos", alu_out, 1);
    drive(rty(3'd1, 3'd2, 3'd3, 4'b0111), 16'h0001, 16'hFFFF, 16'h0000);
    ck("R3 slt pos<neg", alu_out, 0);
    drive(rty(3'd1, 3'd2, 3'd3, 4'b0111), 16'h0042, 16'h0042, 16'h0000);
    ck("R3 slt equal", alu_out, 0);
  endtask

  task automatic t_jr;
    drive(rty(3'd4, 3'd0, 3'd5, 4'b1000), 16'h4321, 16'h0000, 16'h0100);
    ck("R4 jr redirect", W'(redirect), 1);
    ck("R4 jr target", target, 16'h4321);
    ck("R4 jr no write", W'(wr_en), 0);
    drive(rty(3'd4, 3'd0, 3'd5, 4'b1011), 16'h4321, 16'h0000, 16'h0100);
    ck("R4 unused funct no write", W'(wr_en), 0);
    ck("R4 unused funct no redirect", W'(redirect), 0);
  endtask

  task automatic t_addi;
    drive(ity(3'b001, 3'd1, 3'd2, 7'h7F), 16'h0500, 16'h000A, 16'h0000);
    ck("R5 addi result", alu_out, 16'h0009);
    ck("R5 addi wr_idx", W'(wr_idx), 2);
    ck("R5 addi wr_en", W'(wr_en), 1);
  endtask

  task automatic t_mem;
    drive(ity(3'b100, 3'd1, 3'd3, 7'h40), 16'h0100, 16'h0000, 16'h0000);
    ck("R6 lw addr", alu_out, 16'h00C0);
    ck("R6 lw mem_rd", W'({mem_rd, mem_wr}), 2);
    ck("R6 lw wr_idx", W'(wr_idx), 3);
    ck("R6 lw wr_en", W'(wr_en), 1);
    drive(ity(3'b101, 3'd1, 3'd3, 7'h05), 16'h0100, 16'hBEEF, 16'h0000);
    ck("R6 sw addr", alu_out, 16'h0105);
    ck("R6 sw mem_wr", W'({mem_rd, mem_wr}), 1);
    ck("R6 sw no write", W'(wr_en), 0);
  endtask

  task automatic t_jump;
    drive({3'b010, 13'h1ABC}, 16'h0000, 16'h0000, 16'h0200);
    ck("R7 j redirect", W'(redirect), 1);
    ck("R7 j target", target, 16'h1ABC);
    ck("R7 j no write", W'(wr_en), 0);
    drive({3'b011, 13'h1FFF}, 16'h0000, 16'h0000, 16'h0200);
    ck("R7 jal target", target, 16'h1FFF);
    ck("R7 jal wr_idx", W'(wr_idx), 7);
    ck("R7 jal wr_en", W'(wr_en), 1);
    ck("R7 jal link", alu_out, 16'h0202);
  endtask

  task automatic t_branch;
    drive(ity(3'b110, 3'd1, 3'd2, 7'h7E), 16'h0033, 16'h0033, 16'h0100);
    ck("R8 beq taken", W'(redirect), 1);
    ck("R8 beq target", target, 16'h0100);
    drive(ity(3'b110, 3'd1, 3'd2, 7'h7E), 16'h0033, 16'h0034, 16'h0100);
    ck("R8 beq not taken", W'(redirect), 0);
    ck("R10 target idle", target, 0);
    drive(ity(3'b111, 3'd1, 3'd2, 7'h05), 16'h0033, 16'h0034, 16'h0100);
    ck("R8 bne taken", W'(redirect), 1);
    ck("R8 bne target", target, 16'h0107);
    drive(ity(3'b111, 3'd1, 3'd2, 7'h05), 16'h0033, 16'h0033, 16'h0100);
    ck("R8 bne not taken", W'(redirect), 0);
    ck("R8 branch no write", W'(wr_en), 0);
  endtask

  task automatic t_r0;
    drive(ity(3'b001, 3'd1, 3'd0, 7'h01), 16'h0000, 16'h0004, 16'h0000);
    ck("R9 addi to r0", W'(wr_en), 0);
    drive(ity(3'b100, 3'd1, 3'd0, 7'h01), 16'h0010, 16'h0000, 16'h0000);
    ck("R9 lw to r0", W'(wr_en), 0);
    ck("R9 lw to r0 still reads", W'(mem_rd), 1);
    drive(rty(3'd1, 3'd2, 3'd0, 4'b0000), 16'h0001, 16'h0001, 16'h0000);
    ck("R9 add to r0", W'(wr_en), 0);
  endtask

  initial begin
    instr = '0; rs_val = '0; rt_val = '0; pc = '0;
    t_idle;
    t_rtype;
    t_shift;
    t_slt;
    t_jr;
    t_addi;
    t_mem;
    t_jump;
    t_branch;
    t_r0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule